// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Sequencer

This block sits on the host side of a parallel NOR flash bus and runs word-program and sector-erase operations for the rest of the chip. A client hands over one request at a time on a valid/ready handshake: an erase/program select, a target word address and, for program, the data word. The sequencer sends the unlock command writes as timed bus cycles. Each cycle has an address setup phase, a write-enable pulse and a hold phase, and each phase lasts a parameterised number of clock cycles.

Once the last write of the sequence has completed, the block starts back-to-back read cycles and watches the toggle bit. The flash is treated as finished when two reads in a row return the same bit 6 and bit 7 also confirms completion. The block then waits a settle interval, so that the full data word can be trusted, and pulses `done_o`. If the toggle bit keeps moving for too many reads, the block writes the read-reset command, pulses `done_o` and raises `timeout_o` in the same cycle.

Top module: `nor_op_seq`

## Requirements
- R1: `req_ready_o` is high only while the block is idle, with chip enable deasserted. A request is taken on the first clock edge where valid and ready are both high, and ready stays low until `done_o`.
- R2: A program request emits exactly four write cycles, in this order: (0x5555, 0x00AA), (0x2AAA, 0x0055), (0x5555, 0x00A0), then (target address, data word). Addresses are zero-extended to the address width.
- R3: An erase request emits exactly six write cycles, in this order: (0x5555, 0x00AA), (0x2AAA, 0x0055), (0x5555, 0x0080), (0x5555, 0x00AA), (0x2AAA, 0x0055), then (target address, 0x0030).
- R4: The output enable stays high whenever the write enable is low. Chip enable is low during every write and every read cycle.
- R5: Every write-enable low pulse lasts exactly `PULSE_CYC` clock cycles, which is chosen to be well above 5 ns.
- R6: No read cycle starts before the final write of the sequence has completed (the 4th for program, the 6th for erase).
- R7: The operation completes on the first read, from the second read onward, whose bit 6 equals bit 6 of the previous read and whose bit 7 confirms completion. For program, bit 7 confirms when it equals bit 7 of the data word. For erase, bit 7 confirms when it reads 1.
- R8: Two consecutive reads with equal bit 6 do not complete the operation while bit 7 does not yet confirm. Polling continues.
- R9: After the completing read, `done_o` rises no earlier than `SETTLE_CYC` cycles after that read's output enable went high.
- R10: If `POLL_MAX` reads pass without completion, the block writes (0x5555, 0x00F0) and then pulses `done_o` with `timeout_o` high in the same cycle. `timeout_o` is never high without `done_o`.
- R11: During reset, ready is high, chip enable, output enable and write enable are high, and `done_o` is low.
- R12: The block drives the data bus only while chip enable is low and output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_erase_i | input | 1 | 1 = sector erase, 0 = word program |
| req_addr_i | input | AW | Target word address |
| req_data_i | input | DW | Data word for program |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | High with done_o when polling gave up |
| fl_addr_o | output | AW | Flash address bus |
| fl_dq_o | output | DW | Flash data out |
| fl_dq_oe_o | output | 1 | Data bus drive enable |
| fl_dq_i | input | DW | Flash data in |
| fl_ce_no | output | 1 | Chip enable, active low |
| fl_oe_no | output | 1 | Output enable, active low |
| fl_we_no | output | 1 | Write enable, active low |

## Verification
The bench aims at four corner cases of the completion rule.

The first is a flash that is ready before the first poll. A design that trusts a single read, instead of a pair of reads, would finish one read early.

The second is a busy phase where bit 6 holds still for several reads while bit 7 is still inverted. A design that ignores bit 7 would report done far too soon.

The third covers ready data whose bit 6 happens to equal the last toggled value, and ready data where it does not. A design with an off-by-one in its read pairing would get one of these two cases wrong.

The fourth is a flash that never settles. Here the bench expects exactly `POLL_MAX` reads followed by the reset write. It also checks that no read slips in before the last command write, and that the settle gap is honoured.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [2:0] {S_IDLE, S_CMD, S_POLL, S_SETTLE, S_ABORT} seq_st_e;
  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_ACT, B_HOLD} bus_st_e;

  localparam logic [15:0] ADR_U1 = 16'h5555;
  localparam logic [15:0] ADR_U2 = 16'h2AAA;
  localparam logic [7:0] CODE_AA  = 8'hAA;
  localparam logic [7:0] CODE_55  = 8'h55;
  localparam logic [7:0] CODE_PGM = 8'hA0;
  localparam logic [7:0] CODE_ERS = 8'h80;
  localparam logic [7:0] CODE_SEC = 8'h30;
  localparam logic [7:0] CODE_RST = 8'hF0;

  function automatic logic [2:0] last_step(input logic erase);
    return erase ? 3'd5 : 3'd3;
  endfunction
endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  input  logic [DW-1:0] dq_i,
  output logic          oe_no,
  output logic          we_no
);
  import nor_seq_pkg::*;

  localparam int MAXC = (PULSE_CYC > RD_CYC ? PULSE_CYC : RD_CYC) +
                        SETUP_CYC + HOLD_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  bus_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          rd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= B_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_o <= '0;
    end else begin
      unique case (st_q)
        B_IDLE: if (start_i) begin
          rd_q    <= rd_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          cnt_q   <= CW'(SETUP_CYC - 1);
          st_q    <= B_SETUP;
        end
        B_SETUP: if (cnt_q == '0) begin
          cnt_q <= rd_q ? CW'(RD_CYC - 1) : CW'(PULSE_CYC - 1);
          st_q  <= B_ACT;
        end else cnt_q <= cnt_q - 1'b1;
        B_ACT: if (cnt_q == '0) begin
          if (rd_q) rdata_o <= dq_i;
          cnt_q <= CW'(HOLD_CYC - 1);
          st_q  <= B_HOLD;
        end else cnt_q <= cnt_q - 1'b1;
        B_HOLD: if (cnt_q == '0) st_q <= B_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign idle_o  = (st_q == B_IDLE);
  assign done_o  = (st_q == B_HOLD) && (cnt_q == '0);
  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign dq_oe_o = (st_q != B_IDLE) && !rd_q;
  assign we_no   = !((st_q == B_ACT) && !rd_q);
  assign oe_no   = !((st_q == B_ACT) && rd_q);
endmodule

// File: rtl/nor_poll_track.sv
module nor_poll_track #(
  parameter int POLL_MAX = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic rd_valid_i,
  input  logic dq7_i,
  input  logic dq6_i,
  input  logic erase_i,
  input  logic exp7_i,
  output logic complete_o,
  output logic limit_o
);
  localparam int NW = $clog2(POLL_MAX + 1);

  logic          prev6_q, have_q;
  logic [NW-1:0] n_q;
  logic          dq7_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev6_q <= 1'b0;
      have_q  <= 1'b0;
      n_q     <= '0;
    end else if (clear_i) begin
      have_q <= 1'b0;
      n_q    <= '0;
    end else if (rd_valid_i) begin
      prev6_q <= dq6_i;
      have_q  <= 1'b1;
      n_q     <= n_q + 1'b1;
    end
  end

  // erase finishes with bit 7 at 1, program with the true data bit
  assign dq7_ok     = erase_i ? dq7_i : (dq7_i == exp7_i);
  assign complete_o = rd_valid_i && have_q && (dq6_i == prev6_q) && dq7_ok;
  assign limit_o    = rd_valid_i && !complete_o && (n_q == NW'(POLL_MAX - 1));
endmodule

// File: rtl/nor_op_seq.sv
module nor_op_seq #(
  parameter int AW         = 20,
  parameter int DW         = 16,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 3,
  parameter int HOLD_CYC   = 1,
  parameter int RD_CYC     = 3,
  parameter int POLL_MAX   = 64,
  parameter int SETTLE_CYC = 50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_erase_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          done_o,
  output logic          timeout_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe_o,
  input  logic [DW-1:0] fl_dq_i,
  output logic          fl_ce_no,
  output logic          fl_oe_no,
  output logic          fl_we_no
);
  import nor_seq_pkg::*;

  localparam int SW = $clog2(SETTLE_CYC + 1);

  seq_st_e       st_q;
  logic          erase_q, done_q, tmo_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    step_q;
  logic [SW-1:0] settle_q;

  logic          bus_idle, bus_done, bus_start, bus_rd;
  logic [DW-1:0] bus_rdata, cmd_data;
  logic [AW-1:0] cmd_addr;
  logic          poll_ok, poll_limit;

  always_comb begin
    cmd_addr = AW'(ADR_U1);
    cmd_data = DW'(CODE_AA);
    if (st_q == S_ABORT) begin
      cmd_data = DW'(CODE_RST);
    end else begin
      unique case (step_q)
        3'd0: ;
        3'd1: begin cmd_addr = AW'(ADR_U2); cmd_data = DW'(CODE_55); end
        3'd2: cmd_data = erase_q ? DW'(CODE_ERS) : DW'(CODE_PGM);
        3'd3: if (!erase_q) begin cmd_addr = addr_q; cmd_data = data_q; end
        3'd4: begin cmd_addr = AW'(ADR_U2); cmd_data = DW'(CODE_55); end
        default: begin cmd_addr = addr_q; cmd_data = DW'(CODE_SEC); end
      endcase
    end
  end

  assign bus_rd    = (st_q == S_POLL);
  assign bus_start = bus_idle &&
                     (st_q == S_CMD || st_q == S_POLL || st_q == S_ABORT);

  nor_bus_cycle #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .RD_CYC(RD_CYC)
  ) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (bus_start),
    .rd_i    (bus_rd),
    .addr_i  (cmd_addr),
    .wdata_i (cmd_data),
    .idle_o  (bus_idle),
    .done_o  (bus_done),
    .rdata_o (bus_rdata),
    .addr_o  (fl_addr_o),
    .dq_o    (fl_dq_o),
    .dq_oe_o (fl_dq_oe_o),
    .dq_i    (fl_dq_i),
    .oe_no   (fl_oe_no),
    .we_no   (fl_we_no)
  );

  nor_poll_track #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (st_q == S_IDLE),
    .rd_valid_i (bus_done && st_q == S_POLL),
    .dq7_i      (bus_rdata[7]),
    .dq6_i      (bus_rdata[6]),
    .erase_i    (erase_q),
    .exp7_i     (data_q[7]),
    .complete_o (poll_ok),
    .limit_o    (poll_limit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      erase_q  <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      step_q   <= '0;
      settle_q <= '0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          erase_q <= req_erase_i;
          addr_q  <= req_addr_i;
          data_q  <= req_data_i;
          step_q  <= '0;
          st_q    <= S_CMD;
        end
        S_CMD: if (bus_done) begin
          if (step_q == last_step(erase_q)) st_q <= S_POLL;
          else step_q <= step_q + 1'b1;
        end
        S_POLL: if (poll_ok) begin
          settle_q <= SW'(SETTLE_CYC);
          st_q     <= S_SETTLE;
        end else if (poll_limit) st_q <= S_ABORT;
        S_SETTLE: if (settle_q == '0) begin
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end else settle_q <= settle_q - 1'b1;
        S_ABORT: if (bus_done) begin
          done_q <= 1'b1;
          tmo_q  <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign fl_ce_no    = (st_q == S_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = tmo_q;
endmodule

// File: rtl/nor_op_seq_chk.sv
module nor_op_seq_chk #(
  parameter int PULSE_CYC = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic done_o,
  input logic timeout_o,
  input logic fl_ce_no,
  input logic fl_oe_no,
  input logic fl_we_no,
  input logic fl_dq_oe_o
);
  logic [15:0] we_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_lo_q <= '0;
    else if (!fl_we_no) we_lo_q <= we_lo_q + 1'b1;
    else we_lo_q <= '0;
  end

  p_oe_high_in_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_no |-> (fl_oe_no && !fl_ce_no));
  p_ce_on_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> !fl_ce_no);
  p_pulse_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no) |-> (we_lo_q == 16'(PULSE_CYC)));
  p_dq_drive_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_dq_oe_o |-> (fl_oe_no && !fl_ce_no));
  p_busy_not_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_ce_no |-> !req_ready_o);
  p_tmo_with_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);
  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind nor_op_seq nor_op_seq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o),
  .fl_ce_no    (fl_ce_no),
  .fl_oe_no    (fl_oe_no),
  .fl_we_no    (fl_we_no),
  .fl_dq_oe_o  (fl_dq_oe_o)
);

// File: tb/nor_op_seq_tb.sv
module nor_op_seq_tb;
  localparam int AW = 20, DW = 16, PULSE = 3, HOLD = 1;
  localparam int PMAX = 64, SETTLE = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_erase = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, done, tmo, dq_oe, ce_n, oe_n, we_n;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] dq_o, dq_i;

  nor_op_seq #(.AW(AW), .DW(DW), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
               .POLL_MAX(PMAX), .SETTLE_CYC(SETTLE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_erase_i(req_erase), .req_addr_i(req_addr), .req_data_i(req_data),
    .done_o(done), .timeout_o(tmo), .fl_addr_o(fl_addr), .fl_dq_o(dq_o),
    .fl_dq_oe_o(dq_oe), .fl_dq_i(dq_i), .fl_ce_no(ce_n), .fl_oe_no(oe_n),
    .fl_we_no(we_n));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  bit armed = 0;

  // flash model
  bit busy, t6, erase_m;
  int busy_left, freeze_left, cfg_b, cfg_f;
  logic [DW-1:0] word_m, d_m;
  logic [AW-1:0] wl_a [0:15];
  logic [DW-1:0] wl_d [0:15];
  logic [DW-1:0] rlog [0:127];
  int wcount, rcount, wc_first, last_rd_cyc;
  int r4_bad = 0, r5_bad = 0, r12_bad = 0, we_cnt = 0;

  always_comb begin
    dq_i = word_m;
    if (busy) begin
      dq_i = '0;
      dq_i[7] = erase_m ? 1'b0 : ~d_m[7];
      dq_i[6] = t6;
    end
  end

  always @(posedge clk) cyc++;

  always @(posedge we_n) if (armed && rst_n) begin
    if (wcount < 16) begin wl_a[wcount] = fl_addr; wl_d[wcount] = dq_o; end
    wcount++;
    if (dq_o[7:0] == 8'hF0) busy = 0;
    else if ((wcount == 4 && wl_d[2][7:0] == 8'hA0) ||
             (wcount == 6 && dq_o[7:0] == 8'h30)) begin
      erase_m = (wcount == 6);
      d_m = dq_o;
      word_m = erase_m ? '1 : dq_o;
      t6 = 0; busy_left = cfg_b; freeze_left = cfg_f;
      busy = (cfg_b > 0);
    end
  end

  always @(posedge oe_n) if (armed && rst_n) begin
    if (rcount == 0) wc_first = wcount;
    if (rcount < 128) rlog[rcount] = dq_i;
    rcount++;
    last_rd_cyc = cyc;
    if (busy) begin
      if (freeze_left > 0) freeze_left--; else t6 = ~t6;
      busy_left--;
      if (busy_left == 0) busy = 0;
    end
  end

  always @(negedge clk) if (armed && rst_n) begin
    if (!we_n && (!oe_n || ce_n)) r4_bad++;
    if (!oe_n && ce_n) r4_bad++;
    if (dq_oe && (!oe_n || ce_n)) r12_bad++;
    if (!we_n) we_cnt++;
    else if (we_cnt != 0) begin
      if (we_cnt != PULSE) r5_bad++;
      we_cnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit er, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int b, input int f);
    logic [AW-1:0] ea [0:7];
    logic [DW-1:0] ed [0:7];
    int nexp, n, exp_reads, done_cyc;
    bit found, got_tmo;
    string rq;
    wcount = 0; rcount = 0; wc_first = -1; busy = 0; cfg_b = b; cfg_f = f;
    ea[0] = 'h5555; ed[0] = 'h00AA; ea[1] = 'h2AAA; ed[1] = 'h0055;
    if (er) begin
      ea[2] = 'h5555; ed[2] = 'h0080; ea[3] = 'h5555; ed[3] = 'h00AA;
      ea[4] = 'h2AAA; ed[4] = 'h0055; ea[5] = a; ed[5] = 'h0030; nexp = 6;
    end else begin
      ea[2] = 'h5555; ed[2] = 'h00A0; ea[3] = a; ed[3] = d; nexp = 4;
    end
    rq = er ? "R3" : "R2";
    @(negedge clk);
    req_valid = 1; req_erase = er; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0; req_erase = $urandom % 2; req_data = DW'($urandom);
    chk(req_ready == 1'b0, "R1", "ready low while busy", req_ready, 0);
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    got_tmo = tmo; done_cyc = cyc;
    chk(n < 20000, "R7", "done seen", n, 0);
    // expected completion from the read log
    found = 0; exp_reads = PMAX;
    for (int r = 1; r < rcount && r < PMAX && !found; r++)
      if (rlog[r][6] == rlog[r-1][6] && (er ? rlog[r][7] : rlog[r][7] == d[7])) begin
        found = 1; exp_reads = r + 1;
      end
    if (!found) begin ea[nexp] = 'h5555; ed[nexp] = 'h00F0; nexp++; end
    chk(wcount == nexp, found ? rq : "R10", "write count", wcount, nexp);
    for (int i = 0; i < nexp && i < wcount; i++) begin
      chk(wl_a[i] == ea[i], i >= nexp - 1 && !found ? "R10" : rq, "write addr", wl_a[i], ea[i]);
      chk(wl_d[i] == ed[i], i >= nexp - 1 && !found ? "R10" : rq, "write data", wl_d[i], ed[i]);
    end
    chk(wc_first == (er ? 6 : 4), "R6", "writes before first read", wc_first, er ? 6 : 4);
    chk(rcount == exp_reads, f > 0 ? "R8" : "R7", "read count", rcount, exp_reads);
    chk(got_tmo == !found, "R10", "timeout flag", got_tmo, !found);
    if (found)
      chk(done_cyc - last_rd_cyc >= SETTLE && done_cyc - last_rd_cyc <= SETTLE + HOLD + 4,
          "R9", "settle gap", done_cyc - last_rd_cyc, SETTLE);
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R1", "idle after done", req_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && ce_n == 1 && oe_n == 1 && we_n == 1 && done == 0,
        "R11", "reset outputs", {req_ready, ce_n, oe_n, we_n, done}, 5'b11110);
    rst_n = 1; armed = 1;
    repeat (2) @(negedge clk);
    // directed corners
    run_op(0, 'h12345, 16'h00C0, 0, 0);   // ready at first read
    run_op(1, 'h00400, 16'h0000, 0, 0);
    run_op(0, 'h00001, 16'h0040, 3, 0);   // bit6 ends equal to last toggle
    run_op(0, 'h00002, 16'h0000, 3, 0);   // bit6 ends different
    run_op(0, 'h00003, 16'h0080, 6, 3);   // frozen bit6, bit7 still wrong
    run_op(1, 'h7FFFF, 16'h0000, 5, 4);
    run_op(0, 'hABCDE, 16'h5AA5, 100000, 0); // never finishes
    run_op(1, 'h55555, 16'h0000, 100000, 0);
    for (int k = 0; k < 20; k++) begin
      int b, f;
      b = $urandom % 12;
      f = (b > 2) ? ($urandom % 3) : 0;
      run_op($urandom % 2, AW'($urandom), DW'($urandom), b, f);
    end
    chk(r4_bad == 0, "R4", "enable overlap count", r4_bad, 0);
    chk(r5_bad == 0, "R5", "bad pulse widths", r5_bad, 0);
    chk(r12_bad == 0, "R12", "bus drive violations", r12_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule